// File: doc/BRIEF.md
# Delay-Slot Fetch Sequencer

This block generates the instruction fetch address for a small scalar core whose instruction store is 4 KiB and is addressed in whole words. It holds three program counters: the current one (driven out as the fetch address), the previous one, and the next one. Each accepted step moves the window forward by one word. A taken branch does not redirect the fetch at once. It only rewrites the next counter, so the instruction in the delay slot still runs before control reaches the target.

A branch request carries a condition, a target and a "likely" flag. When a likely branch is not taken, the delay-slot instruction is cancelled: the current counter moves straight to the next one. A direct load installs a new counter value. The host uses it to start the core, and the jump logic uses it to redirect. While a step is accepted, a strobe tells the register file to clear general register 0.

Top module: `pc_seq`

## Requirements
- R1: While reset is active and immediately after it, the fetch address is 0 and the previous PC is 0. The next PC is 4, so the first accepted step fetches address 4.
- R2: Every stored PC has its two low bits cleared and lies within 12 bits. Branch targets and load values are forced into this form, so an input of 0x123 becomes 0x120.
- R3: An accepted step copies the fetch address into the previous PC and the next PC into the fetch address. It then advances the next PC by 4.
- R4: A taken ordinary branch (request=1, condition=1, likely=0) replaces only the next PC with the aligned target. The fetch address and the previous PC are unchanged in that cycle. The following step fetches the delay-slot word, and the step after that fetches the target.
- R5: A not-taken ordinary branch (request=1, condition=0, likely=0) has no effect on any PC.
- R6: A taken likely branch (request=1, condition=1, likely=1) behaves exactly like a taken ordinary branch.
- R7: A not-taken likely branch (request=1, condition=0, likely=1) skips the delay slot. In the next cycle the fetch address takes the old next PC and the next PC becomes that value plus 4. The previous PC is unchanged.
- R8: A PC load copies the fetch address into the previous PC, sets the fetch address to the aligned value, and sets the next PC to that value plus 4.
- R9: When requests coincide in one cycle, only one is served: a load first, then a branch, then a step. The requests that are not served have no effect.
- R10: The register-0 clear strobe is high combinationally in exactly the cycles in which a step is accepted. It is low in idle cycles and in cycles where a load or a branch takes priority over the step.
- R11: All PC arithmetic wraps within 12 bits, so a step from 0xFFC fetches 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance by one instruction |
| br_req_i | input | 1 | Branch request |
| br_cond_i | input | 1 | Branch condition resolved true |
| br_likely_i | input | 1 | Branch is of the likely kind |
| br_target_i | input | 12 | Branch target address |
| load_i | input | 1 | Direct PC load request |
| load_val_i | input | 12 | Value for PC load |
| fetch_addr_o | output | 12 | Current PC, used as the fetch address |
| prev_pc_o | output | 12 | Previous PC |
| zero_clr_o | output | 1 | Clear strobe for general register 0 |

## Verification
The bench builds the block with its default parameters: a 12-bit address and 4-byte words. With these values a short stepping run from a load near 0xFF8 reaches the wrap from 0xFFC to 0x000. Unaligned targets and load values exercise the masking of the two low bits. Every combination of the branch condition and the likely flag is driven, and the cycles after each one are followed to confirm that the delay slot runs or is skipped. Cycles with a load, a branch and a step all raised together exercise the priority order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,
    ACT_STEP  = 3'd1,
    ACT_TAKEN = 3'd2,
    ACT_SKIP  = 3'd3,
    ACT_LOAD  = 3'd4
  } pc_act_t;
endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
  import pcseq_pkg::*;
(
  input  logic    step_i,
  input  logic    br_req_i,
  input  logic    br_cond_i,
  input  logic    br_likely_i,
  input  logic    load_i,
  output pc_act_t act_o,
  output logic    ev_step_o,
  output logic    ev_taken_o,
  output logic    ev_skip_o,
  output logic    ev_load_o
);
  // Priority: load, then branch, then step.
  always_comb begin
    act_o = ACT_IDLE;
    if (load_i)
      act_o = ACT_LOAD;
    else if (br_req_i && br_cond_i)
      act_o = ACT_TAKEN;
    else if (br_req_i && br_likely_i)
      act_o = ACT_SKIP;
    else if (br_req_i)
      act_o = ACT_IDLE;
    else if (step_i)
      act_o = ACT_STEP;
  end

  assign ev_step_o  = (act_o == ACT_STEP);
  assign ev_taken_o = (act_o == ACT_TAKEN);
  assign ev_skip_o  = (act_o == ACT_SKIP);
  assign ev_load_o  = (act_o == ACT_LOAD);
endmodule

// File: rtl/pcseq_regs.sv
module pcseq_regs
  import pcseq_pkg::*;
#(
  parameter int AW = 12,
  parameter int WB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pc_act_t       act_i,
  input  logic [AW-1:0] br_target_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] npc_q,
  output logic [AW-1:0] prev_q
);
  localparam logic [AW-1:0] LOW_MASK = AW'(WB - 1);
  localparam logic [AW-1:0] STRIDE   = AW'(WB);

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return a & ~LOW_MASK;
  endfunction

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a);
    return align(a + STRIDE);
  endfunction

  logic [AW-1:0] load_aligned;
  assign load_aligned = align(load_val_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      prev_q <= '0;
      npc_q  <= STRIDE;
    end else begin
      case (act_i)
        ACT_STEP: begin
          prev_q <= align(pc_q);
          pc_q   <= align(npc_q);
          npc_q  <= advance(npc_q);
        end
        ACT_TAKEN: begin
          npc_q <= align(br_target_i);
        end
        ACT_SKIP: begin
          pc_q  <= align(npc_q);
          npc_q <= advance(npc_q);
        end
        ACT_LOAD: begin
          prev_q <= align(pc_q);
          pc_q   <= load_aligned;
          npc_q  <= advance(load_aligned);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pcseq_pkg::*;
#(
  parameter int AW = 12,
  parameter int WB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          br_req_i,
  input  logic          br_cond_i,
  input  logic          br_likely_i,
  input  logic [AW-1:0] br_target_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic [AW-1:0] prev_pc_o,
  output logic          zero_clr_o
);
  pc_act_t       act;
  logic          ev_step, ev_taken, ev_skip, ev_load;
  logic [AW-1:0] pc_q, npc_q, prev_q;

  pcseq_arbiter u_arb (
    .step_i      (step_i),
    .br_req_i    (br_req_i),
    .br_cond_i   (br_cond_i),
    .br_likely_i (br_likely_i),
    .load_i      (load_i),
    .act_o       (act),
    .ev_step_o   (ev_step),
    .ev_taken_o  (ev_taken),
    .ev_skip_o   (ev_skip),
    .ev_load_o   (ev_load)
  );

  pcseq_regs #(.AW(AW), .WB(WB)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_i       (act),
    .br_target_i (br_target_i),
    .load_val_i  (load_val_i),
    .pc_q        (pc_q),
    .npc_q       (npc_q),
    .prev_q      (prev_q)
  );

  assign fetch_addr_o = pc_q;
  assign prev_pc_o    = prev_q;
  assign zero_clr_o   = ev_step;
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk #(
  parameter int AW = 12,
  parameter int WB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_i,
  input logic          load_i,
  input logic [AW-1:0] br_target_i,
  input logic [AW-1:0] load_val_i,
  input logic [AW-1:0] fetch_addr_o,
  input logic [AW-1:0] prev_pc_o,
  input logic          zero_clr_o,
  input logic [AW-1:0] npc_q,
  input logic          ev_step,
  input logic          ev_taken,
  input logic          ev_skip,
  input logic          ev_load
);
  localparam logic [AW-1:0] LMASK = AW'(WB - 1);

  // R2
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fetch_addr_o & LMASK) == '0) && ((npc_q & LMASK) == '0));

  // R3
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (fetch_addr_o == $past(npc_q)) && (prev_pc_o == $past(fetch_addr_o)));

  // R4
  taken_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_taken |=> (npc_q == ($past(br_target_i) & ~LMASK)) && $stable(fetch_addr_o) && $stable(prev_pc_o));

  // R7
  skip_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> (fetch_addr_o == $past(npc_q)) && $stable(prev_pc_o));

  // R8
  load_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (fetch_addr_o == ($past(load_val_i) & ~LMASK)) && (prev_pc_o == $past(fetch_addr_o))
                && (npc_q == AW'(fetch_addr_o + AW'(WB))));

  // R9
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> ev_load && !ev_taken && !ev_skip && !ev_step);

  // R10
  zero_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_clr_o |-> step_i && !load_i);
endmodule

bind pc_seq pc_seq_chk #(.AW(AW), .WB(WB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_i       (step_i),
  .load_i       (load_i),
  .br_target_i  (br_target_i),
  .load_val_i   (load_val_i),
  .fetch_addr_o (fetch_addr_o),
  .prev_pc_o    (prev_pc_o),
  .zero_clr_o   (zero_clr_o),
  .npc_q        (npc_q),
  .ev_step      (ev_step),
  .ev_taken     (ev_taken),
  .ev_skip      (ev_skip),
  .ev_load      (ev_load)
);

// File: tb/pc_seq_test.sv
`timescale 1ns/1ps
module pc_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0, br_req_i = 1'b0, br_cond_i = 1'b0, br_likely_i = 1'b0, load_i = 1'b0;
  logic [11:0] br_target_i = '0, load_val_i = '0;
  logic [11:0] fetch_addr_o, prev_pc_o;
  logic        zero_clr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int m_pc = 0, m_next = 4, m_prev = 0;

  always #4 clk = ~clk;

  pc_seq uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_req_i(br_req_i),
    .br_cond_i(br_cond_i), .br_likely_i(br_likely_i), .br_target_i(br_target_i),
    .load_i(load_i), .load_val_i(load_val_i), .fetch_addr_o(fetch_addr_o),
    .prev_pc_o(prev_pc_o), .zero_clr_o(zero_clr_o)
  );

  function automatic int fold(input int v);
    return (v / 4 * 4) % 4096;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle, compare against the model, then advance the model.
  task automatic cyc(input string tag, input bit st, input bit br, input bit cnd,
                     input bit lk, input int tgt, input bit ld, input int lv);
    bit exp_clr;
    @(negedge clk);
    step_i = st; br_req_i = br; br_cond_i = cnd; br_likely_i = lk;
    br_target_i = 12'(tgt); load_i = ld; load_val_i = 12'(lv);
    #1;
    exp_clr = st && !br && !ld;
    check(tag, int'(fetch_addr_o), m_pc, "fetch");
    check(tag, int'(prev_pc_o), m_prev, "prev");
    check(tag, int'(zero_clr_o), int'(exp_clr), "zero_clr");
    if (ld) begin
      m_prev = m_pc; m_pc = fold(lv); m_next = fold(m_pc + 4);
    end else if (br) begin
      if (cnd) m_next = fold(tgt);
      else if (lk) begin m_pc = m_next; m_next = fold(m_pc + 4); end
    end else if (st) begin
      m_prev = m_pc; m_pc = m_next; m_next = fold(m_next + 4);
    end
  endtask

  task automatic stepn(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(fetch_addr_o), 0, "reset fetch");
    check("R1", int'(prev_pc_o), 0, "reset prev");
    rst_n = 1'b1;
    cyc("R1", 0, 0, 0, 0, 0, 0, 0);
    stepn("R3", 3);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0);
    // ordinary taken, delay slot executes
    cyc("R4", 0, 1, 1, 0, 12'h100, 0, 0);
    stepn("R4", 3);
    // ordinary not taken
    cyc("R5", 0, 1, 0, 0, 12'h300, 0, 0);
    stepn("R5", 2);
    // likely taken
    cyc("R6", 0, 1, 1, 1, 12'h200, 0, 0);
    stepn("R6", 3);
    // likely not taken: slot skipped
    cyc("R7", 0, 1, 0, 1, 12'h500, 0, 0);
    stepn("R7", 2);
    cyc("R7", 0, 1, 0, 1, 12'h500, 0, 0);
    cyc("R7", 0, 1, 0, 1, 12'h500, 0, 0);
    stepn("R7", 1);
    // load with unaligned value
    cyc("R8", 0, 0, 0, 0, 0, 1, 12'h7FF);
    stepn("R8", 2);
    // unaligned branch target
    cyc("R2", 0, 1, 1, 0, 12'h123, 0, 0);
    stepn("R2", 3);
    // wrap
    cyc("R11", 0, 0, 0, 0, 0, 1, 12'hFF8);
    stepn("R11", 4);
    // priority cases
    cyc("R9", 1, 1, 1, 0, 12'h040, 1, 12'h800);
    cyc("R9", 1, 1, 1, 1, 12'h040, 0, 0);
    cyc("R9", 1, 1, 0, 1, 12'h040, 0, 0);
    cyc("R9", 1, 1, 0, 0, 12'h040, 0, 0);
    cyc("R10", 1, 0, 0, 0, 0, 1, 12'h010);
    stepn("R10", 3);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0);
    // reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    step_i = 1'b0; br_req_i = 1'b0; load_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = 0; m_next = 4; m_prev = 0;
    cyc("R1", 1, 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule